// File: doc/BRIEF.md
# Streaming Neighbour Contrast Unit

This block sits inline on the readout stream that carries log-encoded pixel codes from an image array towards processor memory. Every beat holds eight 10-bit codes from one row. For each pixel the block emits the signed difference between its right-hand neighbour and the pixel itself. Because the codes are logarithmic, this plain subtraction is the contrast between the two pixels, and the result does not depend on the illumination level. The contrast is formed as the data moves, so no separate processing pass over memory is needed.

The right-hand neighbour of the last lane is lane 0 of the following beat. For that reason the unit keeps one beat in a holding register and releases it only when the next beat of the same row is on its input. A beat marked as the end of a row has no right-hand neighbour for its last pixel. That contrast is forced to zero, and the held beat is released without waiting for more input. Both sides use valid/ready handshakes and carry start-of-row and end-of-row flags.

Top module: `nc_contrast_stream`

## Requirements
- R1: For lanes 0 to 6, output lane i equals pixel i+1 minus pixel i of the same beat, as an 11-bit two's-complement value. Lane i of a bus occupies bits [i*W +: W], where W is 10 on the input and 11 on the output.
- R2: When a beat is not an end-of-row beat, its output lane 7 equals lane 0 of the next input beat minus its own lane 7, as an 11-bit two's-complement value.
- R3: When a beat is an end-of-row beat, its output lane 7 is zero.
- R4: A held end-of-row beat is presented on the output with out_valid high even while in_valid is low.
- R5: A beat that is not at the end of a row is not presented until the next beat is offered on the input. While nothing is held, out_valid stays low.
- R6: While a beat is held and out_ready is low, in_ready is low and the held beat's output fields stay unchanged.
- R7: out_sor and out_eor carry the row flags of the beat being presented.
- R8: Each accepted input beat produces exactly one output beat, in order, with no loss and no duplicate. An input beat is accepted into an occupied holding register only in the same cycle that the held beat is taken by the output.
- R9: During and immediately after reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_data | input | 80 | Eight 10-bit log-encoded pixel codes, lane 0 in the low bits |
| in_sor | input | 1 | Input beat is the first beat of a row |
| in_eor | input | 1 | Input beat is the last beat of a row |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can take the output beat |
| out_data | output | 88 | Eight 11-bit signed contrast values, lane 0 in the low bits |
| out_sor | output | 1 | Presented beat is the first beat of a row |
| out_eor | output | 1 | Presented beat is the last beat of a row |

## Verification
The bench looks hardest at the beat seam and the row end. Rows of one to four beats are driven with codes that swing between 0 and 1023, so the differences reach the full range of ±1023. A design that took lane 7's neighbour from the wrong beat, or that dropped the sign bit, would give wrong values on that lane. A row of a single beat, followed by an idle input, catches a design that waits for more data before flushing, or that does not zero the last contrast. Random-looking stall and gap patterns, together with a long directed stall, expose beats that are lost, repeated, or altered while the output is back-pressured.

// File: rtl/nc_contrast_pkg.sv
package nc_contrast_pkg;

  // Row flags travelling with every beat.
  typedef struct packed {
    logic sor;
    logic eor;
  } nc_mark_t;

endpackage

// File: rtl/nc_lane_diff.sv
module nc_lane_diff #(
  parameter int PIX_W  = 10,
  parameter int DIFF_W = PIX_W + 1
) (
  input  logic [PIX_W-1:0]  cur_pix,
  input  logic [PIX_W-1:0]  nxt_pix,
  input  logic              force_zero,
  output logic [DIFF_W-1:0] diff
);

  // Neighbour minus current; one extra bit keeps the sign for log codes.
  function automatic logic [DIFF_W-1:0] pix_diff(input logic [PIX_W-1:0] cur,
                                                 input logic [PIX_W-1:0] nxt);
    logic [DIFF_W-1:0] a;
    logic [DIFF_W-1:0] b;
    a = DIFF_W'(nxt);
    b = DIFF_W'(cur);
    return a - b;
  endfunction

  assign diff = force_zero ? '0 : pix_diff(cur_pix, nxt_pix);

endmodule

// File: rtl/nc_hold_stage.sv
module nc_hold_stage
  import nc_contrast_pkg::*;
#(
  parameter int BEAT_W = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              emit,
  input  logic              out_ready,
  input  logic [BEAT_W-1:0] in_beat,
  input  nc_mark_t          in_mark,
  output logic              held_v,
  output logic [BEAT_W-1:0] held_beat,
  output nc_mark_t          held_mark
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_v    <= 1'b0;
      held_beat <= '0;
      held_mark <= '0;
    end else if (load) begin
      held_v    <= 1'b1;
      held_beat <= in_beat;
      held_mark <= in_mark;
    end else if (emit) begin
      held_v    <= 1'b0;
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_v && !out_ready |=> held_v && $stable(held_beat) && $stable(held_mark));

endmodule

// File: rtl/nc_contrast_stream.sv
module nc_contrast_stream
  import nc_contrast_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int PIX_W  = 10,
  localparam int DIFF_W = PIX_W + 1,
  localparam int IN_W   = LANES * PIX_W,
  localparam int OUT_W  = LANES * DIFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  input  logic             in_sor,
  input  logic             in_eor,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  output logic             out_sor,
  output logic             out_eor
);

  logic            held_v;
  logic [IN_W-1:0] held_beat;
  nc_mark_t        held_mark;
  nc_mark_t        in_mark;
  logic            accept_w;
  logic            emit_w;
  logic            flush_w;

  assign in_mark  = '{sor: in_sor, eor: in_eor};
  assign flush_w  = held_v && held_mark.eor;
  assign out_valid = held_v && (held_mark.eor || in_valid);
  assign in_ready = !held_v || out_ready;
  assign accept_w = in_valid && in_ready;
  assign emit_w   = out_valid && out_ready;
  assign out_sor  = held_mark.sor;
  assign out_eor  = held_mark.eor;

  nc_hold_stage #(.BEAT_W(IN_W)) hold_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept_w),
    .emit      (emit_w),
    .out_ready (out_ready),
    .in_beat   (in_data),
    .in_mark   (in_mark),
    .held_v    (held_v),
    .held_beat (held_beat),
    .held_mark (held_mark)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [PIX_W-1:0] nxt_pix;
    logic             zero_w;
    if (l == LANES - 1) begin : g_seam
      assign nxt_pix = in_data[PIX_W-1:0];
      assign zero_w  = held_mark.eor;
    end else begin : g_inner
      assign nxt_pix = held_beat[(l+1)*PIX_W +: PIX_W];
      assign zero_w  = 1'b0;
    end
    nc_lane_diff #(.PIX_W(PIX_W), .DIFF_W(DIFF_W)) diff_i (
      .cur_pix    (held_beat[l*PIX_W +: PIX_W]),
      .nxt_pix    (nxt_pix),
      .force_zero (zero_w),
      .diff       (out_data[l*DIFF_W +: DIFF_W])
    );
  end

  // R4
  eor_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_w |-> out_valid);

  // R5
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !held_v |-> !out_valid);

  // R3
  seam_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eor |-> out_data[OUT_W-1 -: DIFF_W] == '0);

  // R8
  swap_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_v && accept_w |-> emit_w);

  // R9
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid && in_ready);

endmodule

// File: tb/nc_contrast_stream_tb_top.sv
module nc_contrast_stream_tb_top;

  localparam int LN = 8;
  localparam int PW = 10;
  localparam int DW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [LN*PW-1:0] in_data = '0;
  logic          in_sor = 1'b0;
  logic          in_eor = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [LN*DW-1:0] out_data;
  logic          out_sor;
  logic          out_eor;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int pix [32];

  always #2.5 clk = ~clk;

  nc_contrast_stream dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sor(in_sor), .in_eor(in_eor),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sor(out_sor), .out_eor(out_eor)
  );

  // {beats[3:0], seed[15:0], stall[7:0], gap[7:0]}; seed 0 = 0/1023 zigzag
  localparam logic [35:0] VEC [6] = '{
    {4'd1, 16'd5,    8'h00, 8'h00},
    {4'd2, 16'd0,    8'h00, 8'h00},
    {4'd3, 16'd123,  8'h55, 8'h00},
    {4'd4, 16'd999,  8'h00, 8'h32},
    {4'd4, 16'd0,    8'hC0, 8'h0C},
    {4'd3, 16'd4242, 8'hE0, 8'h11}
  };

  function automatic int pixval(int seed, int idx);
    if (seed == 0) return (idx % 2 == 1) ? 1023 : 0;
    return (seed * 37 + idx * idx * 113 + idx * seed) % 1024;
  endfunction

  function automatic logic [DW-1:0] exp_diff(int a, int b);
    int d;
    d = b - a;
    return d[DW-1:0];
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic check_beat(int b, int beats);
    bit ok;
    logic [DW-1:0] e;
    logic [DW-1:0] a;
    ok = 1'b1;
    for (int l = 0; l < LN; l++) begin
      int k;
      k = b * LN + l;
      e = (k == beats * LN - 1) ? '0 : exp_diff(pix[k], pix[k+1]);
      a = out_data[l*DW +: DW];
      if (a !== e) begin
        ok = 1'b0;
        // R1 R2 R3: lanes inside the beat, the seam lane, the zeroed end lane
        check(1'b0, (l == LN-1) ? ((b == beats-1) ? "R3" : "R2") : "R1",
              $sformatf("beat %0d lane %0d", b, l), a, e);
      end
    end
    if (ok) checks++;
    // R7
    check(out_sor == (b == 0) && out_eor == (b == beats-1), "R7", "row flags",
          {out_sor, out_eor}, {b == 0, b == beats-1});
  endtask

  task automatic run_row(int beats, int seed, logic [7:0] stall, logic [7:0] gap);
    int in_idx;
    int out_idx;
    int cyc;
    for (int i = 0; i < beats * LN; i++) pix[i] = pixval(seed, i);
    in_idx = 0;
    out_idx = 0;
    cyc = 0;
    while (out_idx < beats && cyc < 500) begin
      @(negedge clk);
      out_ready = !stall[cyc % 8];
      if (in_idx < beats && !gap[cyc % 8]) begin
        in_valid = 1'b1;
        for (int l = 0; l < LN; l++) in_data[l*PW +: PW] = PW'(pix[in_idx*LN + l]);
        in_sor = (in_idx == 0);
        in_eor = (in_idx == beats - 1);
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (out_valid && out_ready) begin
        // R5: a beat that is not the row end waits for its successor
        check(out_idx < in_idx - 1 || out_idx == beats - 1 ||
              (in_valid && in_idx == out_idx + 1), "R5", "early release",
              out_idx, in_idx);
        check_beat(out_idx, beats);
        out_idx++;
      end
      if (in_valid && in_ready) in_idx++;
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    #1;
    // R8
    check(out_idx == beats && in_idx == beats, "R8", "beat count", out_idx, beats);
    check(!out_valid, "R8", "duplicate beat after row", out_valid, 0);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic [LN*DW-1:0] snap;
    repeat (3) @(negedge clk);
    // R9
    check(!out_valid && in_ready, "R9", "in reset", {out_valid, in_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R9", "after reset", {out_valid, in_ready}, 1);

    for (int v = 0; v < 6; v++)
      run_row(int'(VEC[v][35:32]), int'(VEC[v][31:16]), VEC[v][15:8], VEC[v][7:0]);

    // R4: single-beat row flushes with an idle input
    for (int i = 0; i < LN; i++) pix[i] = 100 * i + 3;
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1;
    in_sor = 1'b1;
    in_eor = 1'b1;
    for (int l = 0; l < LN; l++) in_data[l*PW +: PW] = PW'(pix[l]);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(out_valid, "R4", "flush without input", out_valid, 1);
    check_beat(0, 1);
    @(negedge clk);
    #1;
    check(!out_valid, "R8", "single beat repeated", out_valid, 0);

    // R6: long stall with a neighbour waiting, then release
    for (int i = 0; i < 2 * LN; i++) pix[i] = (i * 211 + 17) % 1024;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_sor = 1'b1;
    in_eor = 1'b0;
    for (int l = 0; l < LN; l++) in_data[l*PW +: PW] = PW'(pix[l]);
    @(negedge clk);
    in_sor = 1'b0;
    in_eor = 1'b1;
    for (int l = 0; l < LN; l++) in_data[l*PW +: PW] = PW'(pix[LN + l]);
    #1;
    snap = out_data;
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      #1;
      check(!in_ready && out_valid, "R6", "stall blocks input",
            {in_ready, out_valid}, 1);
      check(out_data == snap, "R6", "held output stable", out_data, snap);
    end
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    check(out_valid && in_ready, "R8", "release handshake", {out_valid, in_ready}, 3);
    check_beat(0, 2);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(out_valid, "R4", "end beat after stall", out_valid, 1);
    check_beat(1, 2);
    @(negedge clk);
    #1;
    check(!out_valid, "R8", "stall duplicate", out_valid, 0);

    finish_run();
  end

endmodule